// File: doc/BRIEF.md
# SCL Period Generator

This block times the clock line of an I2C master from a faster reference clock. It alternates between a low phase, where it pulls SCL down through an open-drain drive, and a high phase, where it lets the line go. Each phase lasts a programmed cycle count plus a fixed overhead. Two count pairs are kept, one for standard speed and one for fast speed. A control field picks which pair is in use.

The low phase is timed from the block's own pull-down, so the fall time of the line is part of the low period. The high phase is timed only from the cycle in which the line is sensed high. A target that keeps SCL low therefore stretches the clock. The block tells the bit engine which phase is running. It also gives a one-cycle mark at the point where a START hold time would be met. START/STOP sequencing and data shifting belong to the bit engine.

States: `ST_IDLE` releases the line. `ST_LOW` drives it low. `ST_WAIT` has released the line and waits for it to read high. `ST_HIGH` times the high phase. Transitions:
- idle→low, when the enable bit is set.
- low→wait, when the low count expires.
- wait→high, when SCL is sensed high.
- high→low, when the high count expires.
- any state→idle, when the enable bit is clear.

Top module: `scl_period_gen`

## Requirements
- R1: After reset, and while the enable bit ctrl[0] is 0, `scl_pull` is 0 (line released) and neither `ph_low` nor `ph_high` is asserted.
- R2: A low phase asserts `scl_pull` and `ph_low` for exactly L+1 consecutive cycles, where L is the selected low count.
- R3: A high phase asserts `ph_high` with `scl_pull` at 0 for exactly H+8 consecutive cycles, where H is the selected high count.
- R4: High-phase timing starts only in a cycle in which `scl_in` is sampled 1. While a target holds SCL low after release, `ph_high` and `ph_low` both stay 0.
- R5: With ctrl[2]=1 and ctrl[1]=0 (control value 0x4 with enable) the fast pair is used. Any other setting of those two bits (such as 0x2) uses the standard pair.
- R6: Count registers are written through `cfg_addr`: 0 is standard high, 1 is standard low, 2 is fast high, 3 is fast low. A write made while ctrl[0]=1 is ignored.
- R7: In each high phase, `hold_mark` pulses exactly once, in cycle H+3 of that phase (counting from 1).
- R8: Clearing ctrl[0] releases the line and drops both phase outputs on the next clock edge. The next enable starts afresh with a low phase.
- R9: While enabled, the phases alternate: low first, then high, and never both at once.
- R10: A count of zero gives a low phase of 1 cycle and a high phase of 8 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl | input | 3 | bit0 enable, bit1 standard speed, bit2 fast speed |
| cfg_we | input | 1 | Count register write strobe |
| cfg_addr | input | 2 | Count register select |
| cfg_wdata | input | CNT_W | Count value to write |
| scl_in | input | 1 | Sensed SCL level |
| scl_pull | output | 1 | 1 drives SCL low, 0 releases it |
| ph_low | output | 1 | Low phase being timed |
| ph_high | output | 1 | High phase being timed |
| hold_mark | output | 1 | START-hold point pulse within the high phase |

## Verification
The bench builds the block with CNT_W=6 and uses counts between 0 and 5. Every low and high phase therefore lasts only a handful of cycles, and many full alternations fit into a short run. The small width also makes the zero-count edge reachable with the same expected-length formula. The bench drives both speed codes, writes made while the block runs, a target stretch of several cycles, and a disable in the middle of a phase.

// File: rtl/scl_period_gen_pkg.sv
package scl_period_gen_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_WAIT = 2'd2,
        ST_HIGH = 2'd3
    } scl_state_e;

    // fixed overheads added to the programmed counts
    localparam int HIGH_EXTRA = 8;
    localparam int LOW_EXTRA  = 1;
    localparam int HOLD_EXTRA = 3;

    localparam logic [1:0] ADDR_STD_HI  = 2'd0;
    localparam logic [1:0] ADDR_STD_LO  = 2'd1;
    localparam logic [1:0] ADDR_FAST_HI = 2'd2;
    localparam logic [1:0] ADDR_FAST_LO = 2'd3;
    localparam int         NUM_COUNTS   = 4;
endpackage

// File: rtl/scl_count_bank.sv
module scl_count_bank
    import scl_period_gen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             locked,
    input  logic             fast_sel,
    output logic [CNT_W-1:0] hi_cnt,
    output logic [CNT_W-1:0] lo_cnt
);
    logic [NUM_COUNTS-1:0][CNT_W-1:0] regs_q;

    // R6: writes land only while the generator is disabled
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else if (wr_en && !locked) begin
            for (int i = 0; i < NUM_COUNTS; i++) begin
                if (wr_addr == 2'(i)) regs_q[i] <= wr_data;
            end
        end
    end

    // R5: pair selection
    always_comb begin
        if (fast_sel) begin
            hi_cnt = regs_q[ADDR_FAST_HI];
            lo_cnt = regs_q[ADDR_FAST_LO];
        end else begin
            hi_cnt = regs_q[ADDR_STD_HI];
            lo_cnt = regs_q[ADDR_STD_LO];
        end
    end
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_period_gen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] hi_cnt,
    input  logic [CNT_W-1:0] lo_cnt,
    input  logic             scl_in,
    output logic             scl_pull,
    output logic             ph_low,
    output logic             ph_high,
    output logic             hold_mark
);
    localparam int CW = CNT_W + 1;

    scl_state_e      st_q, st_d;
    logic [CW-1:0]   cnt_q;
    logic [CW-1:0]   hi_end, lo_end, hold_pt;
    logic            low_last, high_last;

    assign hi_end    = {1'b0, hi_cnt} + CW'(HIGH_EXTRA - 1);
    assign lo_end    = {1'b0, lo_cnt} + CW'(LOW_EXTRA - 1);
    assign hold_pt   = {1'b0, hi_cnt} + CW'(HOLD_EXTRA - 1);
    assign low_last  = (cnt_q == lo_end);
    assign high_last = (cnt_q == hi_end);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (en) st_d = ST_LOW;
            ST_LOW:  if (!en) st_d = ST_IDLE;
                     else if (low_last) st_d = ST_WAIT;
            ST_WAIT: if (!en) st_d = ST_IDLE;
                     else if (scl_in) st_d = ST_HIGH;
            ST_HIGH: if (!en) st_d = ST_IDLE;
                     else if (high_last) st_d = ST_LOW;
            default: st_d = ST_IDLE;
        endcase
    end

    // phase counter restarts on every state change
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              cnt_q <= '0;
        else if (st_d != st_q)                   cnt_q <= '0;
        else if (st_q == ST_LOW || st_q == ST_HIGH) cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        scl_pull  = 1'b0;
        ph_low    = 1'b0;
        ph_high   = 1'b0;
        hold_mark = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_LOW: begin
                scl_pull = 1'b1;
                ph_low   = 1'b1;
            end
            ST_WAIT: ;
            ST_HIGH: begin
                ph_high   = 1'b1;
                hold_mark = (cnt_q == hold_pt);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen
    import scl_period_gen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       ctrl,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [CNT_W-1:0] cfg_wdata,
    input  logic             scl_in,
    output logic             scl_pull,
    output logic             ph_low,
    output logic             ph_high,
    output logic             hold_mark
);
    logic             en;
    logic             fast_sel;
    logic [CNT_W-1:0] hi_cnt, lo_cnt;

    assign en       = ctrl[0];
    assign fast_sel = ctrl[2] & ~ctrl[1];

    scl_count_bank #(.CNT_W(CNT_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_addr  (cfg_addr),
        .wr_data  (cfg_wdata),
        .locked   (en),
        .fast_sel (fast_sel),
        .hi_cnt   (hi_cnt),
        .lo_cnt   (lo_cnt)
    );

    scl_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .hi_cnt    (hi_cnt),
        .lo_cnt    (lo_cnt),
        .scl_in    (scl_in),
        .scl_pull  (scl_pull),
        .ph_low    (ph_low),
        .ph_high   (ph_high),
        .hold_mark (hold_mark)
    );
endmodule

// File: rtl/scl_period_gen_chk.sv
module scl_period_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] ctrl,
    input logic       scl_in,
    input logic       scl_pull,
    input logic       ph_low,
    input logic       ph_high,
    input logic       hold_mark
);
    p_release_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[0] |=> (!scl_pull && !ph_low && !ph_high));

    p_low_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ph_low |-> scl_pull);

    p_high_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ph_high |-> !scl_pull);

    p_one_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ph_low, ph_high}));

    p_high_needs_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ph_high) |-> $past(scl_in));

    p_mark_in_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_mark |-> ph_high);

    p_low_follows_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ph_high) && $past(ctrl[0])) |-> ph_low);
endmodule

bind scl_period_gen scl_period_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl),
    .scl_in    (scl_in),
    .scl_pull  (scl_pull),
    .ph_low    (ph_low),
    .ph_high   (ph_high),
    .hold_mark (hold_mark)
);

// File: tb/scl_period_gen_test.sv
`timescale 1ns/1ps
module scl_period_gen_test;
    localparam int CNT_W = 6;

    typedef struct {
        bit    hi;
        int    len;
        int    mark;
    } phase_item_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       ctrl = 3'b000;
    logic             cfg_we = 1'b0;
    logic [1:0]       cfg_addr = 2'd0;
    logic [CNT_W-1:0] cfg_wdata = '0;
    logic             tgt_hold = 1'b0;
    logic             scl_in;
    logic             scl_pull, ph_low, ph_high, hold_mark;

    int checks = 0;
    int failures = 0;
    phase_item_t exp_q[$];

    always #2 clk = ~clk;

    // open-drain line: low if block pulls or target holds
    assign scl_in = ~scl_pull & ~tgt_hold;

    scl_period_gen #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .scl_in(scl_in),
        .scl_pull(scl_pull), .ph_low(ph_low), .ph_high(ph_high),
        .hold_mark(hold_mark)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = CNT_W'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic push_pair(input int lo, input int hi, input string tag);
        phase_item_t l, h;
        l.hi = 1'b0; l.len = lo + 1; l.mark = 0;
        h.hi = 1'b1; h.len = hi + 8; h.mark = hi + 3;
        exp_q.push_back(l);
        exp_q.push_back(h);
        $display("expect %s low=%0d high=%0d", tag, l.len, h.len);
    endtask

    task automatic drain();
        int g = 0;
        while (exp_q.size() > 0 && g < 2000) begin
            @(negedge clk);
            g++;
        end
        chk(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);
    endtask

    task automatic turn_off();
        @(negedge clk);
        ctrl = 3'b000;
        @(negedge clk);
        chk(!scl_pull && !ph_low && !ph_high, "R8 released after disable",
            {scl_pull, ph_low, ph_high}, 0);
        repeat (2) @(negedge clk);
    endtask

    // monitor: measures run lengths and compares with scoreboard
    int run_l = 0, run_h = 0, mark_pos = 0, mark_n = 0;

    task automatic end_run(input bit hi, input int len, input int mpos, input int mn);
        phase_item_t e;
        if (exp_q.size() == 0) return;
        e = exp_q.pop_front();
        chk(e.hi == hi, "R9 phase order", int'(hi), int'(e.hi));
        if (hi) begin
            chk(len == e.len, "R3 high length", len, e.len);
            chk(mpos == e.mark && mn == 1, "R7 hold mark position", mpos, e.mark);
        end else begin
            chk(len == e.len, "R2 low length", len, e.len);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (ph_low) run_l++;
            else if (run_l > 0) begin
                end_run(1'b0, run_l, 0, 0);
                run_l = 0;
            end
            if (ph_high) begin
                run_h++;
                if (hold_mark) begin
                    mark_pos = run_h;
                    mark_n++;
                end
            end else if (run_h > 0) begin
                end_run(1'b1, run_h, mark_pos, mark_n);
                run_h = 0; mark_pos = 0; mark_n = 0;
            end
        end
    end

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!scl_pull && !ph_low && !ph_high, "R1 reset state",
            {scl_pull, ph_low, ph_high}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        wr(2'd0, 5); wr(2'd1, 4); wr(2'd2, 2); wr(2'd3, 3);

        // R1: speed chosen, enable clear, nothing happens
        ctrl = 3'b010;
        repeat (4) @(negedge clk);
        chk(!scl_pull && !ph_low && !ph_high, "R1 idle while disabled",
            {scl_pull, ph_low, ph_high}, 0);

        // standard pair, control value 0x2 (R5)
        push_pair(4, 5, "R5 std"); push_pair(4, 5, "R5 std");
        ctrl = 3'b011;
        drain();

        // R6: write while running is ignored
        wr(2'd1, 9);
        wr(2'd0, 1);
        push_pair(4, 5, "R6 locked"); push_pair(4, 5, "R6 locked");
        drain();
        turn_off();
        push_pair(4, 5, "R6 after reenable");
        ctrl = 3'b011;
        drain();
        turn_off();

        // R5: fast pair, control value 0x4
        push_pair(3, 2, "R5 fast"); push_pair(3, 2, "R5 fast");
        ctrl = 3'b101;
        drain();
        turn_off();

        // R5: both speed bits set falls back to standard
        push_pair(4, 5, "R5 both bits");
        ctrl = 3'b111;
        drain();
        turn_off();

        // R4: target stretches the clock
        push_pair(3, 2, "R4 stretch");
        ctrl = 3'b101;
        while (!ph_low) @(negedge clk);
        while (ph_low) @(negedge clk);
        tgt_hold = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(!ph_high && !ph_low, "R4 no phase while held",
                {ph_low, ph_high}, 0);
        end
        tgt_hold = 1'b0;
        drain();
        turn_off();

        // R10: zero counts
        wr(2'd2, 0); wr(2'd3, 0);
        push_pair(0, 0, "R10 zero"); push_pair(0, 0, "R10 zero");
        ctrl = 3'b101;
        drain();
        turn_off();

        // R8: disable in the middle of a low phase
        ctrl = 3'b011;
        repeat (3) @(negedge clk);
        chk(scl_pull == 1'b1, "R2 pulling in low phase", scl_pull, 1);
        ctrl = 3'b000;
        @(negedge clk);
        chk(!scl_pull && !ph_low && !ph_high, "R8 mid-phase release",
            {scl_pull, ph_low, ph_high}, 0);
        repeat (3) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule